// File: doc/BRIEF.md
# Zoned Bit-Cell Read Decoder

This block recovers bits from a disk read channel that turns at one of four speeds. A synchronised pulse marks each magnetic flux transition. A prescaler divides the system clock by a divisor that the speed zone selects, and this gives a decoder tick. Every four ticks make one bit cell. A cell that ends without a transition yields a 0. A transition yields a 1, and it also re-phases the cell, so the bit comes out exactly two decoder periods after the pulse. This keeps the cell timing locked to the incoming data even when the spindle speed drifts.

Recovered bits move through an 8-bit register that drives a parallel port, and the newest bit enters at the low end. On every eighth bit the finished byte is copied to a holding register and offered on a valid/ready output. A take strobe from the CPU read acts as ready and clears valid. The disk cannot be stalled, so there is no back-pressure. A byte that arrives while valid is still high replaces the held byte, and valid stays high. The same byte event also sets a sticky poll flag that a software branch loop can test. A separate input clears that flag.

Top module: `gcr_read_decoder`

## Requirements
- R1: A synchronous reset clears the port register, the byte counter, the held byte, byte_valid and so_flag, and it restarts the prescaler and the cell phase at zero.
- R2: The decoder tick period is 13 + zone_i system clocks. With no transitions, a 0 bit is shifted in every 4 ticks, that is every 4*(13+zone_i) clocks.
- R3: A flux_i pulse restarts the prescaler and places the cell two ticks from its end. A 1 bit is shifted in exactly 2*(13+zone_i) clocks after the pulse edge.
- R4: Each recovered bit shifts port_q up one place (bit 6 goes to bit 7) and enters at port_q[0], so the first bit of a byte ends in bit 7.
- R5: On every eighth recovered bit after reset, byte_data takes the new port_q value and byte_valid goes high on that same edge.
- R6: byte_take high at an edge clears byte_valid, unless a new byte is completed at that same edge, in which case valid stays high.
- R7: so_flag is set by every byte event and stays set until so_clr is high at an edge with no byte event. A byte event wins over so_clr.
- R8: There is no back-pressure. A byte completed while byte_valid is high overwrites byte_data, and byte_valid stays high.
- R9: A flux_i pulse at the edge that would close a cell takes priority. That cell's 0 bit is dropped, and only the 1 bit follows, 2*(13+zone_i) clocks later.
- R10: The divisor is read from zone_i on every clock. If the prescaler count has already reached the new limit, the tick occurs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| flux_i | input | 1 | Synchronised one-clock flux transition pulse |
| zone_i | input | 2 | Speed zone; divisor is 13 + zone_i |
| port_q | output | 8 | Live shift register driving the parallel port |
| byte_data | output | 8 | Held byte, valid when byte_valid is high |
| byte_valid | output | 1 | Byte-ready indication |
| byte_take | input | 1 | Ready: CPU read that consumes the held byte |
| so_flag | output | 1 | Sticky flag set by each byte event |
| so_clr | input | 1 | Clears so_flag |

## Verification
The hardest situation to reach is a flux pulse that lands on the very clock edge where a cell would close, because the cell phase cannot be seen at the ports. The stimulus first re-phases the decoder with a pulse. It then times the gap to the following zero-bit shift, which reveals the exact edge of the next cell end, and places a second pulse on that edge. A zone change that lowers the divisor below the running count is reached the same way, after a pulse has put the prescaler at a known value. A cycle-accurate behavioural model then follows tens of thousands of clocks of random pulses, zone changes, takes and flag clears.

// File: rtl/gcr_rd_pkg.sv
package gcr_rd_pkg;

  // One recovered bit leaving the cell timer.
  typedef struct packed {
    logic stb;   // a bit cell closed on this clock
    logic val;   // recovered bit value
  } bit_evt_t;

endpackage

// File: rtl/gcr_zone_prescaler.sv
module gcr_zone_prescaler #(
  parameter int BASE_DIV = 13,
  parameter int ZONE_W   = 2,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ZONE_W-1:0] zone_i,
  input  logic              restart_i,
  output logic              tick_o
);

  localparam int MAX_DIV = BASE_DIV + (1 << ZONE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // Divisor follows the zone every clock; a count at or past the limit ticks.
  assign limit  = CNT_W'(BASE_DIV - 1) + CNT_W'(zone_i);
  assign tick_o = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt <= '0;
    end else if (tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the count never runs past the largest divisor.
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_DIV));

  // R3: a restart pulse brings the count back to zero.
  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt == '0));

endmodule

// File: rtl/gcr_cell_timer.sv
module gcr_cell_timer
  import gcr_rd_pkg::*;
#(
  parameter int CELL_TICKS = 4,
  parameter int LEAD_TICKS = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick_i,
  input  logic     flux_i,
  output bit_evt_t evt_o
);

  localparam int PH_W = (CELL_TICKS > 1) ? $clog2(CELL_TICKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_TICKS - 1);
  localparam logic [PH_W-1:0] PH_LOAD = PH_W'(CELL_TICKS - LEAD_TICKS);

  logic [PH_W-1:0] phase;
  logic            seen;

  // A pulse owns the clock it arrives on: no cell closes then.
  assign evt_o.stb = tick_i && !flux_i && (phase == PH_LAST);
  assign evt_o.val = seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      seen  <= 1'b0;
    end else if (flux_i) begin
      phase <= PH_LOAD;
      seen  <= 1'b1;
    end else if (tick_i) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        seen  <= 1'b0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R9: no bit leaves on the clock after a pulse.
  assert_flux_no_bit_R9: assert property (@(posedge clk) disable iff (rst)
    flux_i |=> !evt_o.stb);

  // R3: a cell re-phased by a pulse always closes as a 1.
  assert_flux_yields_one_R3: assert property (@(posedge clk) disable iff (rst)
    (flux_i && !tick_i) |=> !evt_o.stb && seen);

endmodule

// File: rtl/gcr_byte_assembler.sv
module gcr_byte_assembler
  import gcr_rd_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bit_evt_t             evt_i,
  input  logic                 take_i,
  input  logic                 so_clr_i,
  output logic [BYTE_BITS-1:0] port_o,
  output logic [BYTE_BITS-1:0] hold_o,
  output logic                 valid_o,
  output logic                 so_o
);

  localparam int BC_W = $clog2(BYTE_BITS);

  logic [BC_W-1:0]      bcnt;
  logic                 last_bit;
  logic                 byte_evt;
  logic [BYTE_BITS-1:0] shifted;

  assign last_bit = (bcnt == BC_W'(BYTE_BITS - 1));
  assign byte_evt = evt_i.stb && last_bit;
  assign shifted  = {port_o[BYTE_BITS-2:0], evt_i.val};

  always_ff @(posedge clk) begin
    if (rst) begin
      port_o <= '0;
      bcnt   <= '0;
    end else if (evt_i.stb) begin
      port_o <= shifted;
      bcnt   <= last_bit ? '0 : bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o  <= '0;
      valid_o <= 1'b0;
      so_o    <= 1'b0;
    end else begin
      if (take_i)   valid_o <= 1'b0;
      if (so_clr_i) so_o    <= 1'b0;
      if (byte_evt) begin
        hold_o  <= shifted;
        valid_o <= 1'b1;
        so_o    <= 1'b1;
      end
    end
  end

  // R4: a bit strobe moves every older bit up one place.
  assert_port_shift_R4: assert property (@(posedge clk) disable iff (rst)
    evt_i.stb |=> port_o[BYTE_BITS-1:1] == $past(port_o[BYTE_BITS-2:0]));

  // R5: the held byte matches the port on the edge that completes it.
  assert_hold_matches_R5: assert property (@(posedge clk) disable iff (rst)
    byte_evt |=> (hold_o == port_o) && valid_o);

  // R6: a take with no new byte empties the output.
  assert_take_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (take_i && !byte_evt) |=> !valid_o);

  // R7: the poll flag follows every byte event.
  assert_so_set_R7: assert property (@(posedge clk) disable iff (rst)
    byte_evt |=> so_o);

  // R7: the poll flag holds until cleared.
  assert_so_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (so_o && !so_clr_i) |=> so_o);

  // R8: the held byte changes only through a byte event.
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !byte_evt |=> $stable(hold_o));

endmodule

// File: rtl/gcr_read_decoder.sv
module gcr_read_decoder
  import gcr_rd_pkg::*;
#(
  parameter int BASE_DIV   = 13,
  parameter int ZONE_W     = 2,
  parameter int CELL_TICKS = 4,
  parameter int LEAD_TICKS = 2,
  parameter int BYTE_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flux_i,
  input  logic [ZONE_W-1:0]    zone_i,
  output logic [BYTE_BITS-1:0] port_q,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 byte_valid,
  input  logic                 byte_take,
  output logic                 so_flag,
  input  logic                 so_clr
);

  localparam int PRE_W = $clog2(BASE_DIV + (1 << ZONE_W));

  logic     tick;
  bit_evt_t bit_evt;
  logic     rst_d;

  gcr_zone_prescaler #(
    .BASE_DIV (BASE_DIV),
    .ZONE_W   (ZONE_W),
    .CNT_W    (PRE_W)
  ) u_pre (
    .clk       (clk),
    .rst       (rst),
    .zone_i    (zone_i),
    .restart_i (flux_i),
    .tick_o    (tick)
  );

  gcr_cell_timer #(
    .CELL_TICKS (CELL_TICKS),
    .LEAD_TICKS (LEAD_TICKS)
  ) u_cell (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .flux_i (flux_i),
    .evt_o  (bit_evt)
  );

  gcr_byte_assembler #(
    .BYTE_BITS (BYTE_BITS)
  ) u_asm (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (bit_evt),
    .take_i   (byte_take),
    .so_clr_i (so_clr),
    .port_o   (port_q),
    .hold_o   (byte_data),
    .valid_o  (byte_valid),
    .so_o     (so_flag)
  );

  // R1: outputs read cleared on the edge after a reset edge.
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_state_R1: assert (port_q == '0 && byte_data == '0 &&
                                     !byte_valid && !so_flag);
    end
  end

endmodule

// File: tb/gcr_read_decoder_tb.sv
module gcr_read_decoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flux = 1'b0;
  logic [1:0] zone = 2'd0;
  logic       take = 1'b0;
  logic       so_clr = 1'b0;
  logic [7:0] port_q, byte_data;
  logic       byte_valid, so_flag;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gcr_read_decoder u_dut (
    .clk        (clk),
    .rst        (rst),
    .flux_i     (flux),
    .zone_i     (zone),
    .port_q     (port_q),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_take  (take),
    .so_flag    (so_flag),
    .so_clr     (so_clr)
  );

  // Behavioural reference: clock counts and a bit queue.
  int   m_pre, m_ticks, m_nbits;
  bit   m_one;
  bit   m_q[$];
  logic [7:0] m_hold;
  bit   m_valid, m_so;

  function automatic logic [7:0] m_port();
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++)
      if (i < m_q.size()) v[i] = m_q[m_q.size() - 1 - i];
    return v;
  endfunction

  always @(posedge clk) begin
    bit emit, b;
    int div;
    emit = 1'b0; b = 1'b0;
    if (rst) begin
      m_pre = 0; m_ticks = 0; m_one = 0; m_nbits = 0;
      m_q.delete(); m_hold = '0; m_valid = 0; m_so = 0;
    end else begin
      div = 13 + int'(zone);
      if (flux) begin
        m_pre = 0; m_ticks = 2; m_one = 1;
      end else if (m_pre >= div - 1) begin
        m_pre = 0;
        m_ticks++;
        if (m_ticks == 4) begin
          emit = 1; b = m_one; m_one = 0; m_ticks = 0;
        end
      end else begin
        m_pre++;
      end
      if (take) m_valid = 0;
      if (so_clr) m_so = 0;
      if (emit) begin
        m_q.push_back(b);
        if (m_q.size() > 8) void'(m_q.pop_front());
        m_nbits++;
        if (m_nbits == 8) begin
          m_nbits = 0; m_hold = m_port(); m_valid = 1; m_so = 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Continuous comparison against the model (covers R2/R3/R9/R10 timing too).
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(port_q == m_port(), "R4/R10", "port_q", port_q, m_port());
      chk(byte_data == m_hold, "R5/R8", "byte_data", byte_data, m_hold);
      chk(byte_valid == m_valid, "R6/R8", "byte_valid", byte_valid, m_valid);
      chk(so_flag == m_so, "R7", "so_flag", so_flag, m_so);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; flux = 0; take = 0; so_clr = 0;
    step(); step();
    // R1: state seen while reset is held.
    chk(port_q == 8'h00 && byte_data == 8'h00 && !byte_valid && !so_flag,
        "R1", "reset state", {byte_valid, so_flag, port_q}, 0);
    rst = 1'b0;
  endtask

  task automatic send_bit(bit b, int div);
    if (b) begin
      flux = 1'b1; step(); flux = 1'b0;
      repeat (2 * div) step();
    end else begin
      repeat (4 * div) step();
    end
  endtask

  task automatic send_byte(logic [7:0] v, int div);
    for (int i = 7; i >= 0; i--) send_bit(v[i], div);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n, div;
    @(posedge clk);
    chk_on = 1'b1;

    // R3 then R2 then R9 at zone 2.
    zone = 2'd2; div = 15;
    do_reset();
    flux = 1'b1;
    n = 0;
    do begin step(); flux = 1'b0; n++; end while (port_q != 8'h01 && n < 400);
    chk(n == 2 * div + 1, "R3", "clocks flux to 1 bit", n, 2 * div + 1);
    n = 0;
    do begin step(); n++; end while (port_q != 8'h02 && n < 400);
    chk(n == 4 * div, "R2", "clocks per 0 bit", n, 4 * div);
    repeat (4 * div - 1) step();
    flux = 1'b1; step(); flux = 1'b0;
    chk(port_q == 8'h02, "R9", "no 0 bit on colliding edge", port_q, 8'h02);
    n = 0;
    do begin step(); n++; end while (port_q == 8'h02 && n < 400);
    chk(port_q == 8'h05, "R9", "1 bit after collision", port_q, 8'h05);
    chk(n == 2 * div, "R9", "collision delay", n, 2 * div);

    // R10: lower divisor below running count.
    zone = 2'd3;
    do_reset();
    flux = 1'b1; step(); flux = 1'b0;
    repeat (13) step();
    zone = 2'd0;
    n = 0;
    do begin step(); n++; end while (port_q != 8'h01 && n < 400);
    chk(n == 14, "R10", "clocks after zone drop", n, 14);

    // R5, R7, R8, R6 at zone 0.
    zone = 2'd0; div = 13;
    do_reset();
    send_byte(8'hB7, div);
    chk(byte_valid == 1'b1, "R5", "valid after 8 bits", byte_valid, 1);
    chk(byte_data == 8'hB7, "R5", "byte value", byte_data, 8'hB7);
    chk(so_flag == 1'b1, "R7", "flag on byte", so_flag, 1);
    send_byte(8'h41, div);
    chk(byte_valid == 1'b1, "R8", "valid kept on overwrite", byte_valid, 1);
    chk(byte_data == 8'h41, "R8", "overwritten byte", byte_data, 8'h41);
    take = 1'b1; step(); take = 1'b0;
    chk(byte_valid == 1'b0, "R6", "take clears valid", byte_valid, 0);
    chk(so_flag == 1'b1, "R7", "flag stays after take", so_flag, 1);
    so_clr = 1'b1; step(); so_clr = 1'b0;
    chk(so_flag == 1'b0, "R7", "flag cleared", so_flag, 0);

    // Random traffic checked against the model every clock.
    for (int i = 0; i < 40000; i++) begin
      if (i == 20000) do_reset();
      flux   = ($urandom_range(0, 39) == 0);
      take   = ($urandom_range(0, 299) == 0);
      so_clr = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 149) == 0) zone = 2'($urandom_range(0, 3));
      step();
    end
    flux = 0; take = 0; so_clr = 0;
    step();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule